// File: doc/BRIEF.md
# SGI Pending Source-Mask Register Bank

This block is the part of an interrupt distributor that records which CPUs have raised each of the sixteen software-generated interrupts (SGIs) towards one target CPU. Every SGI owns an 8-bit source mask: bit n set means CPU n still has a request outstanding for that SGI. A per-SGI pending flag follows the mask and is high whenever any source bit is set.

Software reaches the masks through two 16-byte windows on a simple valid/ready register bus. Writes to one window OR bits into the masks. Writes to the other window remove bits from them. Reads from either window return the masks, one byte per SGI. Byte, halfword and word accesses are accepted. An access that would cross the top of a window is cut short at the boundary.

When a set write turns an idle SGI into a pending one, the block emits a one-cycle queue request for that SGI, so that downstream delivery logic can pick it up. Priority handling, delivery, acknowledge and SGI generation live elsewhere.

Top module: `sgi_srcmask_bank`

## Requirements
- R1: A synchronous active-high reset clears all source masks, all pending flags, all queue requests and the read response valid. After reset, every read returns zero.
- R2: Address bit 4 selects the window: 0 is the set window and 1 is the clear window. Address bits 3:0 give the first SGI. Size encoding is 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. Data byte i (bits 8i+7:8i) belongs to SGI base+i.
- R3: An accepted read raises rsp_valid for exactly one cycle, in the cycle after acceptance. rsp_rdata then holds the mask of SGI base+i in byte i, for each byte the access covers. All other bytes read as zero. Both windows return the same data.
- R4: A set-window write ORs each covered data byte into its SGI's mask. The pending flag is high from the next cycle whenever the resulting mask is non-zero. A set write never lowers a pending flag.
- R5: A clear-window write clears every mask bit that is 1 in the covered data byte. The pending flag falls in the next cycle when the mask becomes zero, and stays high while any bit remains.
- R6: A data byte of zero, in either window, leaves that SGI's mask and pending flag unchanged. Without a write, pending flags never change.
- R7: queue_req[s] is a one-cycle pulse, issued exactly in the cycle in which pend[s] rises from 0 to 1. A set write that finds SGI s already pending issues no pulse.
- R8: Covered bytes that would fall beyond SGI 15 are dropped. Writes never wrap around to low SGIs, and reads return zero in those lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always accepting) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 5 | Byte address: bit 4 selects the window, bits 3:0 give the SGI |
| req_size | input | 2 | Access size: 0 = byte, 1 = halfword, 2 or 3 = word |
| req_wdata | input | 32 | Write data, byte i for SGI base+i |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 32 | Packed source masks |
| pend | output | 16 | Per-SGI pending flag |
| queue_req | output | 16 | Per-SGI one-cycle request to queue the interrupt |

## Verification
The awkward cases sit at the ends of an SGI's life. The first is a second set write that lands on an SGI that is already pending: it must widen the mask without a new queue pulse. The second is a partial clear that leaves the SGI pending, followed by the clear that finally empties the mask. The stimulus first builds masks with several source bits, then repeats set writes and applies clears one bit group at a time. A word access based at SGI 14 pushes two bytes past the window edge, and the test then reads SGI 0 and 1 to show that nothing wrapped around.

// File: rtl/sgi_bank_pkg.sv
package sgi_bank_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } access_size_e;

  // Number of bytes covered by an access of the given size code.
  function automatic int size_to_len(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_to_len = 1;
      SZ_HALF: size_to_len = 2;
      default: size_to_len = 4;
    endcase
  endfunction

endpackage

// File: rtl/sgi_lane_decode.sv
module sgi_lane_decode
  import sgi_bank_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int SRC_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic [$clog2(NUM_SGI)-1:0]     base_idx,
  input  logic [1:0]                     size_code,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_SGI-1:0]             hit,
  output logic [NUM_SGI-1:0][SRC_W-1:0]  lane_bytes
);

  localparam int LANES = DATA_W / SRC_W;

  int eff_len;

  always_comb begin
    eff_len = size_to_len(size_code);
    if (eff_len > LANES) eff_len = LANES;
  end

  // Route data lane l to SGI base+l; lanes past the top are dropped.
  always_comb begin
    hit        = '0;
    lane_bytes = '0;
    for (int s = 0; s < NUM_SGI; s++) begin
      for (int l = 0; l < LANES; l++) begin
        if ((l < eff_len) && (int'(base_idx) + l == s)) begin
          hit[s]        = 1'b1;
          lane_bytes[s] = wdata[l*SRC_W +: SRC_W];
        end
      end
    end
  end

endmodule

// File: rtl/sgi_src_store.sv
module sgi_src_store #(
  parameter int NUM_SGI = 16,
  parameter int SRC_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           is_clear,
  input  logic [NUM_SGI-1:0]             hit,
  input  logic [NUM_SGI-1:0][SRC_W-1:0]  lane_bytes,
  output logic [NUM_SGI-1:0][SRC_W-1:0]  masks,
  output logic [NUM_SGI-1:0]             pend,
  output logic [NUM_SGI-1:0]             qreq
);

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_sgi
    logic [SRC_W-1:0] nxt_mask;
    logic             upd;

    assign upd      = wr_en & hit[g];
    assign nxt_mask = is_clear ? (masks[g] & ~lane_bytes[g])
                               : (masks[g] | lane_bytes[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        masks[g] <= '0;
        pend[g]  <= 1'b0;
        qreq[g]  <= 1'b0;
      end else begin
        qreq[g] <= 1'b0;
        if (upd) begin
          masks[g] <= nxt_mask;
          pend[g]  <= |nxt_mask;
          qreq[g]  <= ~pend[g] & (|nxt_mask);
        end
      end
    end
  end

endmodule

// File: rtl/sgi_rd_pack.sv
module sgi_rd_pack
  import sgi_bank_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int SRC_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SGI-1:0][SRC_W-1:0]  masks,
  input  logic [$clog2(NUM_SGI)-1:0]     base_idx,
  input  logic [1:0]                     size_code,
  output logic [DATA_W-1:0]              rword
);

  localparam int LANES = DATA_W / SRC_W;
  localparam int IDX_W = $clog2(NUM_SGI);

  int eff_len;
  int idx;

  always_comb begin
    eff_len = size_to_len(size_code);
    if (eff_len > LANES) eff_len = LANES;
    rword = '0;
    idx   = 0;
    for (int l = 0; l < LANES; l++) begin
      idx = int'(base_idx) + l;
      if ((l < eff_len) && (idx < NUM_SGI))
        rword[l*SRC_W +: SRC_W] = masks[idx[IDX_W-1:0]];
    end
  end

endmodule

// File: rtl/sgi_srcmask_bank.sv
module sgi_srcmask_bank #(
  parameter int NUM_SGI = 16,
  parameter int SRC_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [$clog2(NUM_SGI):0]     req_addr,
  input  logic [1:0]                   req_size,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_rdata,
  output logic [NUM_SGI-1:0]           pend,
  output logic [NUM_SGI-1:0]           queue_req
);

  localparam int IDX_W = $clog2(NUM_SGI);

  logic                          accept;
  logic                          wr_en;
  logic                          win_clear;
  logic [IDX_W-1:0]              base_idx;
  logic [NUM_SGI-1:0]            hit;
  logic [NUM_SGI-1:0][SRC_W-1:0] lane_bytes;
  logic [NUM_SGI-1:0][SRC_W-1:0] masks;
  logic [DATA_W-1:0]             rword;

  assign req_ready = 1'b1;
  assign accept    = req_valid & req_ready;
  assign wr_en     = accept & req_write;
  assign win_clear = req_addr[IDX_W];
  assign base_idx  = req_addr[IDX_W-1:0];

  sgi_lane_decode #(.NUM_SGI(NUM_SGI), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_dec (
    .base_idx   (base_idx),
    .size_code  (req_size),
    .wdata      (req_wdata),
    .hit        (hit),
    .lane_bytes (lane_bytes)
  );

  sgi_src_store #(.NUM_SGI(NUM_SGI), .SRC_W(SRC_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .is_clear   (win_clear),
    .hit        (hit),
    .lane_bytes (lane_bytes),
    .masks      (masks),
    .pend       (pend),
    .qreq       (queue_req)
  );

  sgi_rd_pack #(.NUM_SGI(NUM_SGI), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_rd (
    .masks     (masks),
    .base_idx  (base_idx),
    .size_code (req_size),
    .rword     (rword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept & ~req_write;
      if (accept & ~req_write) rsp_rdata <= rword;
    end
  end

endmodule

// File: rtl/sgi_bank_checker.sv
module sgi_bank_checker #(
  parameter int NUM_SGI = 16,
  parameter int DATA_W  = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_write,
  input logic [$clog2(NUM_SGI):0] req_addr,
  input logic                     rsp_valid,
  input logic [NUM_SGI-1:0]       pend,
  input logic [NUM_SGI-1:0]       queue_req
);

  localparam int IDX_W = $clog2(NUM_SGI);

  AST_READ_RSP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R3

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid); // R3

  AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_addr[IDX_W]) |=> ((~pend & $past(pend)) == '0)); // R4

  AST_CLEAR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[IDX_W]) |=> ((pend & ~$past(pend)) == '0)); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> ($stable(pend) && queue_req == '0)); // R6

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_chk
    AST_QREQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      queue_req[g] |-> $rose(pend[g])); // R7
    AST_RISE_GIVES_QREQ: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[g]) |-> queue_req[g]); // R7
  end

endmodule

bind sgi_srcmask_bank sgi_bank_checker #(.NUM_SGI(NUM_SGI), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .pend      (pend),
  .queue_req (queue_req)
);

// File: tb/sim_sgi_srcmask_bank.sv
module sim_sgi_srcmask_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [4:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] pend;
  logic [15:0] queue_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [7:0]  mdl [16];
  logic [15:0] mpend;

  always #5 clk = ~clk;

  sgi_srcmask_bank u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pend(pend), .queue_req(queue_req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic do_write(input bit clr, input logic [3:0] base, input logic [1:0] sz,
                          input logic [31:0] d, input string tag);
    logic [15:0] eq = '0;
    for (int l = 0; l < len_of(sz); l++) begin
      if (int'(base) + l < 16) begin
        int s = int'(base) + l;
        logic [7:0] b  = d[l*8 +: 8];
        logic [7:0] nm = clr ? (mdl[s] & ~b) : (mdl[s] | b);
        if (!mpend[s] && nm != 8'h00) eq[s] = 1'b1;
        mdl[s]   = nm;
        mpend[s] = (nm != 8'h00);
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {clr, base};
    req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(pend == mpend, {tag, " pend"}, {16'h0, pend}, {16'h0, mpend});
    check(queue_req == eq, {tag, " queue_req R7"}, {16'h0, queue_req}, {16'h0, eq});
    @(negedge clk);
    check(queue_req == 16'h0, {tag, " queue_req one-cycle R7"}, {16'h0, queue_req}, 32'h0);
  endtask

  task automatic do_read(input bit win, input logic [3:0] base, input logic [1:0] sz, input string tag);
    logic [31:0] exp = '0;
    for (int l = 0; l < len_of(sz); l++)
      if (int'(base) + l < 16) exp[l*8 +: 8] = mdl[int'(base) + l];
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {win, base}; req_size = sz;
    req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " rsp_valid R3"}, {31'h0, rsp_valid}, 32'h1);
    check(rsp_rdata == exp, {tag, " rdata"}, rsp_rdata, exp);
    @(negedge clk);
    check(rsp_valid == 1'b0, {tag, " rsp_valid drop R3"}, {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic t_reset;
    check(pend == 16'h0, "R1 pend after reset", {16'h0, pend}, 32'h0);
    check(queue_req == 16'h0, "R1 queue_req after reset", {16'h0, queue_req}, 32'h0);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    for (int w = 0; w < 4; w++) do_read(1'b0, 4'(w * 4), 2'd2, "R1 reset read");
  endtask

  task automatic t_set_single;
    do_write(1'b0, 4'd3, 2'd0, 32'h0000_0005, "R4 R2 set byte SGI3");
    do_read(1'b0, 4'd0, 2'd2, "R3 R2 read word 0");
  endtask

  task automatic t_set_repeat;
    do_write(1'b0, 4'd3, 2'd0, 32'h0000_0002, "R7 R4 set already pending");
    do_read(1'b0, 4'd3, 2'd0, "R4 byte read SGI3");
  endtask

  task automatic t_halfword;
    do_write(1'b0, 4'd6, 2'd1, 32'hFFFF_8001, "R2 set halfword SGI6");
    do_read(1'b1, 4'd4, 2'd2, "R3 clear-window read");
    do_read(1'b0, 4'd6, 2'd1, "R3 halfword read");
  endtask

  task automatic t_zero_writes;
    do_write(1'b0, 4'd4, 2'd2, 32'h0000_0000, "R6 zero set word");
    do_write(1'b1, 4'd4, 2'd2, 32'h0000_0000, "R6 zero clear word");
    do_write(1'b1, 4'd6, 2'd1, 32'h8000_0000, "R6 clear with zero lanes");
    do_read(1'b0, 4'd4, 2'd2, "R6 masks unchanged");
  endtask

  task automatic t_clear;
    do_write(1'b1, 4'd3, 2'd0, 32'h0000_0001, "R5 partial clear");
    do_read(1'b1, 4'd3, 2'd0, "R5 after partial clear");
    do_write(1'b1, 4'd3, 2'd0, 32'h0000_00FF, "R5 full clear");
    do_read(1'b0, 4'd0, 2'd2, "R5 after full clear");
  endtask

  task automatic t_truncate;
    do_write(1'b0, 4'd14, 2'd2, 32'hAABB_CCDD, "R8 set word at SGI14");
    do_read(1'b0, 4'd14, 2'd2, "R8 read past top");
    do_read(1'b0, 4'd0, 2'd2, "R8 no wrap to SGI0");
    do_write(1'b1, 4'd15, 2'd2, 32'h0101_01CC, "R8 clear word at SGI15");
    do_read(1'b1, 4'd12, 2'd2, "R8 after top clear");
  endtask

  task automatic t_word_multi;
    do_write(1'b0, 4'd0, 2'd3, 32'h8000_0301, "R7 R2 multi-SGI set");
    do_write(1'b0, 4'd8, 2'd2, 32'h1020_4080, "R7 four rises");
    do_read(1'b1, 4'd8, 2'd2, "R3 word read SGI8");
    do_write(1'b1, 4'd8, 2'd2, 32'h1020_4080, "R5 four falls");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mpend = '0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_single();
    t_set_repeat();
    t_halfword();
    t_zero_writes();
    t_clear();
    t_truncate();
    t_word_multi();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule